// File: doc/BRIEF.md
# Watchdog Timer with Write-Protected Enable

The block is a watchdog built on a free-running up-counter. The counter advances once per system clock. When it passes its all-ones value, it raises a one-cycle CPU reset request and wraps to zero. Software keeps the watchdog quiet by setting a kick flag. Several hardware events also restart the count: an internal reset, entry into sleep, and the start of a flash erase or write. While the clock-stop mode is active the count is frozen.

Five control flags sit on a small write port. Software can turn the watchdog off, but only through an unlock window formed by two window flags: the high window flag must be 1 and the low window flag must be 0. The sequence is to open the window, clear the enable flag, then close the window again. When disabled, the counter keeps its value and resumes from that value when enabled again. Hardware turns the enable back on at an internal reset, at a sleep request, and at a write to the programming-control register.

Top module: `wdt_guard`

## Requirements
- R1: With the watchdog enabled, not stopped and not cleared, `rst_req_o` is high for exactly one cycle after 2^CNT_W counting cycles. In that same cycle the counter wraps to zero, and the next request comes another 2^CNT_W cycles later.
- R2: A write with data bit 2 (kick) set makes `flag_q_o[2]` read 1 after that edge. On the following edge the counter clears and `flag_q_o[2]` returns to 0 without any software action.
- R3: A cycle with `int_rst_i` high, with `prog_start_i` high, or with a write that has data bit 4 (sleep request) set clears the counter on that edge.
- R4: While `stop_mode_i` is high the counter does not advance, and no request is produced.
- R5: While the enable flag (`flag_q_o[3]`) is 0, the counter holds its value. After re-enabling, counting resumes from the held value.
- R6: A write changes the enable flag only if, before the write, `flag_q_o[1]` is 1 and `flag_q_o[0]` is 0. Otherwise data bit 3 is ignored. Bits 0 and 1 are always writable.
- R7: The enable flag is 1 after `rst_ni`, and it is set by `int_rst_i`, by a sleep-request write, and by `prog_ctl_wr_i`. `int_rst_i` also clears the window and kick flags. `flag_q_o[4]` always reads 0.
- R8: If a hardware set of the enable flag and an unlocked software clear fall in the same cycle, the flag ends at 1.
- R9: A counter clear (kick or hardware event) in the same cycle as an overflow wins. The counter goes to zero and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 5 | Flag write data: [0] window low, [1] window high, [2] kick, [3] enable, [4] sleep request |
| int_rst_i | input | 1 | Internal reset active |
| prog_start_i | input | 1 | Flash erase/write start pulse |
| prog_ctl_wr_i | input | 1 | Programming-control register write |
| stop_mode_i | input | 1 | Clock-stop mode active |
| flag_q_o | output | 5 | Flag readback in the same bit layout as the write data |
| rst_req_o | output | 1 | One-cycle CPU reset request |

## Verification
The bench targets the collisions at the edges of the counter. A kick or a flash start that lands exactly on the overflow edge must suppress the request; a design that let it through would reset the CPU right after being serviced. Write attempts with the window closed, or with both window flags set, must leave the enable flag alone; a design that checked only one window flag would let stray writes silence the watchdog. A hardware set that coincides with an unlocked clear must win. After a long disabled stretch, the next request must arrive on time measured from the held count; a design that restarted from zero would be late.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int FLAG_W = 5;

  typedef struct packed {
    logic sleep;
    logic en;
    logic kick;
    logic win_hi;
    logic win_lo;
  } wdt_flags_t;
endpackage

// File: rtl/wdt_flag_ctl.sv
module wdt_flag_ctl
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  wdt_flags_t wdata_i,
  input  logic       int_rst_i,
  input  logic       prog_ctl_wr_i,
  input  logic       cnt_clr_i,
  output wdt_flags_t flags_o,
  output logic       sleep_evt_o
);
  logic en_q, kick_q, win_hi_q, win_lo_q;
  logic en_d, kick_d, win_hi_d, win_lo_d;
  logic force_en, win_open;

  assign sleep_evt_o = we_i & wdata_i.sleep;
  assign force_en    = int_rst_i | sleep_evt_o | prog_ctl_wr_i;
  assign win_open    = win_hi_q & ~win_lo_q;

  always_comb begin
    en_d = en_q;
    if (force_en)                en_d = 1'b1;
    else if (we_i && win_open)   en_d = wdata_i.en;

    kick_d = kick_q;
    if (int_rst_i)               kick_d = 1'b0;
    else if (we_i && wdata_i.kick) kick_d = 1'b1;
    else if (cnt_clr_i)          kick_d = 1'b0;

    win_hi_d = win_hi_q;
    win_lo_d = win_lo_q;
    if (int_rst_i) begin
      win_hi_d = 1'b0;
      win_lo_d = 1'b0;
    end else if (we_i) begin
      win_hi_d = wdata_i.win_hi;
      win_lo_d = wdata_i.win_lo;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b1;
      kick_q   <= 1'b0;
      win_hi_q <= 1'b0;
      win_lo_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      kick_q   <= kick_d;
      win_hi_q <= win_hi_d;
      win_lo_q <= win_lo_d;
    end
  end

  assign flags_o = '{sleep: 1'b0, en: en_q, kick: kick_q,
                     win_hi: win_hi_q, win_lo: win_lo_q};

  p_window_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_open && !force_en) |=> (en_q == $past(en_q)));

  p_force_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_en |=> en_q);

  p_kick_autoclear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_q && cnt_clr_i && !(we_i && wdata_i.kick)) |=> !kick_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stop_i,
  input  logic clr_i,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             run, at_max;

  assign run    = en_i & ~stop_i;
  assign at_max = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
      ovf_q <= at_max;
    end else begin
      ovf_q <= 1'b0;
    end
  end

  assign ovf_o = ovf_q;

  p_pulse_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> !ovf_q);

  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (cnt_q == '0));

  p_clear_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  p_stop_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clr_i) |=> (cnt_q == $past(cnt_q) && !ovf_q));

  p_off_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> (cnt_q == $past(cnt_q)));

  p_clear_beats_ovf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ovf_q);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_we_i,
  input  logic [FLAG_W-1:0] flag_wdata_i,
  input  logic              int_rst_i,
  input  logic              prog_start_i,
  input  logic              prog_ctl_wr_i,
  input  logic              stop_mode_i,
  output logic [FLAG_W-1:0] flag_q_o,
  output logic              rst_req_o
);
  wdt_flags_t wdata, flags;
  logic       sleep_evt, cnt_clr;

  assign wdata = wdt_flags_t'(flag_wdata_i);
  // every restart source, kick included, funnels into one clear
  assign cnt_clr = int_rst_i | sleep_evt | prog_start_i | flags.kick;

  wdt_flag_ctl u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (flag_we_i),
    .wdata_i      (wdata),
    .int_rst_i    (int_rst_i),
    .prog_ctl_wr_i(prog_ctl_wr_i),
    .cnt_clr_i    (cnt_clr),
    .flags_o      (flags),
    .sleep_evt_o  (sleep_evt)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (flags.en),
    .stop_i(stop_mode_i),
    .clr_i (cnt_clr),
    .ovf_o (rst_req_o)
  );

  assign flag_q_o = flags;

  p_sleep_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> !flag_q_o[4]);
endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
  localparam int CNT_W = 6;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flag_we_i = 1'b0;
  logic [4:0] flag_wdata_i = '0;
  logic       int_rst_i = 1'b0, prog_start_i = 1'b0, prog_ctl_wr_i = 1'b0, stop_mode_i = 1'b0;
  logic [4:0] flag_q_o;
  logic       rst_req_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  wdt_guard #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .flag_we_i(flag_we_i), .flag_wdata_i(flag_wdata_i),
    .int_rst_i(int_rst_i), .prog_start_i(prog_start_i), .prog_ctl_wr_i(prog_ctl_wr_i),
    .stop_mode_i(stop_mode_i), .flag_q_o(flag_q_o), .rst_req_o(rst_req_o)
  );

  // reference model built from the requirements; pushes expected request cycles
  int cyc, m_cnt;
  bit m_en, m_kick, m_hi, m_lo;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc = 0; m_cnt = 0; m_en = 1; m_kick = 0; m_hi = 0; m_lo = 0;
    end else begin
      bit slp, frc, win, clr, run;
      slp = flag_we_i && flag_wdata_i[4];
      frc = int_rst_i || slp || prog_ctl_wr_i;            // R7
      win = m_hi && !m_lo;                                 // R6
      clr = int_rst_i || slp || prog_start_i || m_kick;    // R2 R3
      run = m_en && !stop_mode_i;                          // R4 R5
      cyc = cyc + 1;
      if (!clr && run && m_cnt == MAXC) exp_q.push_back(cyc); // R1, R9
      if (clr) m_cnt = 0; else if (run) m_cnt = (m_cnt + 1) & MAXC;
      if (frc) m_en = 1; else if (flag_we_i && win) m_en = flag_wdata_i[3]; // R8
      if (int_rst_i) m_kick = 0; else if (flag_we_i && flag_wdata_i[2]) m_kick = 1;
      else if (clr) m_kick = 0;
      if (int_rst_i) begin m_hi = 0; m_lo = 0; end
      else if (flag_we_i) begin m_hi = flag_wdata_i[1]; m_lo = flag_wdata_i[0]; end
    end
  end

  // monitor: compares observed requests with the queue
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (rst_req_o) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++; $display("FAIL R1/R9 unexpected request actual=cycle %0d expected=none", cyc);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != cyc) begin
            fails++; $display("FAIL R1 request timing actual=cycle %0d expected=cycle %0d", cyc, e);
          end
        end
      end else if (exp_q.size() != 0 && exp_q[0] <= cyc) begin
        int e;
        e = exp_q.pop_front();
        checks++; fails++;
        $display("FAIL R1 missing request actual=none expected=cycle %0d", e);
      end
    end
  end

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++; $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] d);
    flag_we_i = 1'b1; flag_wdata_i = d;
    @(negedge clk);
    flag_we_i = 1'b0; flag_wdata_i = '0;
  endtask

  task automatic disable_seq();
    wr(5'b01010); wr(5'b00010); wr(5'b00000);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    chk("R7 reset flags", flag_q_o, 5'b01000);
    idle(140);                               // R1: two requests at 64 and 128

    wr(5'b01100);                            // R2 kick
    chk("R2 kick visible", flag_q_o, 5'b01100);
    idle(1);
    chk("R2 kick self-clear", flag_q_o, 5'b01000);
    idle(20);

    prog_start_i = 1; idle(1); prog_start_i = 0;   // R3 flash start
    idle(20);
    wr(5'b01010);
    int_rst_i = 1; idle(1); int_rst_i = 0;         // R3 R7 internal reset
    chk("R7 int_rst flags", flag_q_o, 5'b01000);
    idle(10);
    wr(5'b11000);                                  // R3 sleep request
    chk("R7 sleep reads 0", flag_q_o, 5'b01000);
    idle(70);

    stop_mode_i = 1; idle(40); stop_mode_i = 0;    // R4
    idle(80);

    wr(5'b00000);                                  // R6 window closed
    chk("R6 closed window ignored", flag_q_o, 5'b01000);
    wr(5'b01011); wr(5'b00011);                    // R6 both window flags set
    chk("R6 low flag blocks", flag_q_o, 5'b01011);
    wr(5'b01000);

    disable_seq();                                 // R5
    chk("R5 disabled", flag_q_o, 5'b00000);
    idle(150);
    wr(5'b00010); wr(5'b01010);
    chk("R6 unlocked re-enable", flag_q_o, 5'b01010);
    wr(5'b01000);
    idle(80);

    wr(5'b01010);                                  // R8 collision
    flag_we_i = 1; flag_wdata_i = 5'b00010; prog_ctl_wr_i = 1;
    idle(1);
    flag_we_i = 0; flag_wdata_i = '0; prog_ctl_wr_i = 0;
    chk("R8 hw set wins", flag_q_o, 5'b01010);
    wr(5'b01000);

    disable_seq();                                 // R7 forced enables
    prog_ctl_wr_i = 1; idle(1); prog_ctl_wr_i = 0;
    chk("R7 prog ctl write", flag_q_o, 5'b01000);
    disable_seq();
    wr(5'b10000);
    chk("R7 sleep enables", flag_q_o, 5'b01000);

    while (m_cnt != MAXC - 1) @(negedge clk);      // R9 kick on overflow edge
    wr(5'b01100);
    idle(5);
    while (m_cnt != MAXC) @(negedge clk);          // R9 flash start on overflow edge
    prog_start_i = 1; idle(1); prog_start_i = 0;
    idle(75);
    chk("R9 kick state", flag_q_o, 5'b01000);

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R1 pending requests actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    finish_run();
  end
endmodule